// File: doc/BRIEF.md
# Framebuffer Span Copy Engine

This block runs a multi-span row copy inside a 1280 x 1024 pixel framebuffer. A start pulse gives it the word address of a command packet held in a small command memory. The engine fetches the packet one 32-bit word at a time and checks the command word. It then reads how many spans follow and walks the span list. For each span it moves a run of pixels from column 0 of a source row to column 0 of a destination row, one pixel per clock, through a framebuffer read port and a framebuffer write port.

While it works, the engine keeps a bounding range of dirty rows. The range covers every source row and every destination row named by any executed span. It stays in place across commands until a separate clear input empties it. A display refresh path can use it to limit its redraw. The pixel width is a parameter, normally 8 or 24 bits.

Top module: `span_copy_engine`

## Requirements
- R1: Packet word 0 must equal 32'h0000_0405 exactly. Any other value, including one that only shares the low nibble 5, ends the command after one busy cycle. In that case nothing is written and the dirty range does not change.
- R2: The number of spans is bits [31:24] of packet word 1, and the other bits of that word are ignored. A count of zero ends the command after two busy cycles with no writes.
- R3: Span descriptors start at packet word 5 and use three words each: length first, then source, then destination. Each field value is the word shifted right by 3, so bits [2:0] have no effect. A row is bits [12:3] of its word, which is the shifted value modulo 1024.
- R4: A span length above 1280 is cut to 1280. A span length of zero moves no pixel.
- R5: For pixel c, counted from 0 upward, the engine reads address src_row*1280+c on one cycle. On the next cycle it writes the returned data to dst_row*1280+c. Spans run in packet order and read one pixel per cycle. Both memory ports return read data one cycle after the read enable.
- R6: busy rises in the cycle after the accepting clock edge and stays high for 2 + sum over spans of (3, plus L+2 when the span length L is non-zero) cycles. done is a one-cycle pulse in the first cycle after busy falls.
- R7: A start pulse that arrives while busy is high is ignored.
- R8: Each executed span, including one of zero length, widens the dirty range (dirty_row_lo, dirty_row_hi) to include both its source row and its destination row. dirty_valid marks that the range is non-empty, and the range accumulates across commands.
- R9: dirty_clr empties the range, and dirty_valid and both bounds then read 0. If a clear comes in the same cycle as a span update, the range becomes exactly that span's two rows.
- R10: After a synchronous active-low reset, busy, done, dirty_valid and every read or write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| pkt_base | input | CMD_AW | Word address of packet word 0 |
| cmd_rd_en | output | 1 | Command memory read enable |
| cmd_rd_addr | output | CMD_AW | Command memory word address |
| cmd_rd_data | input | 32 | Command word, valid one cycle after read |
| fb_rd_en | output | 1 | Framebuffer read enable |
| fb_rd_addr | output | FB_AW | Framebuffer read pixel address |
| fb_rd_data | input | PIX_W | Pixel, valid one cycle after read |
| fb_wr_en | output | 1 | Framebuffer write enable |
| fb_wr_addr | output | FB_AW | Framebuffer write pixel address |
| fb_wr_data | output | PIX_W | Pixel to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dirty_clr | input | 1 | Empty the dirty row range |
| dirty_valid | output | 1 | Dirty range is non-empty |
| dirty_row_lo | output | ROW_W | Lowest dirty row |
| dirty_row_hi | output | ROW_W | Highest dirty row |

## Verification
The bench predicts the exact busy length of each command from R6 when it builds the packet. On every falling edge it compares busy and done against a cycle counter. busy is due in the first cycle after the accepting edge, and done is due exactly one cycle after the last busy cycle. Each write is due one cycle after its read. The bench compares every cycle that has a write against a queue of expected address and data pairs, which it computes from its own copy of the framebuffer in packet order. The dirty range updates at the edge that closes the fetch of a descriptor. The bench reads it only after done, so that checks do not depend on sampling inside a command. The one exception is the same-cycle clear, which the bench aligns with the fifth cycle after the start edge.

// File: rtl/spancopy_pkg.sv
`timescale 1ns/1ps
// Shared constants and the sequencer state type for the span copy engine.
// Assumes a packet of 32-bit words with descriptors after a fixed header.
package spancopy_pkg;
    localparam logic [31:0] OPC_SPAN_COPY = 32'h0000_0405;
    localparam int          FRAC_BITS     = 3;
    localparam int          HDR_WORDS     = 5;
    localparam int          CNT_LSB       = 24;
    localparam int          CNT_W         = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_CNT, ST_LEN, ST_SRC, ST_DST, ST_MOVE, ST_FIN
    } seq_state_e;
endpackage

// File: rtl/spancopy_field_decode.sv
`timescale 1ns/1ps
// Turns one raw descriptor word into a clamped span length and a row index.
// Assumes FB_ROWS is a power of two, so taking low bits gives the modulo.
module spancopy_field_decode
    import spancopy_pkg::*;
#(
    parameter int FB_COLS = 1280,
    parameter int ROW_W   = 10,
    parameter int LEN_W   = 11
) (
    input  logic [31:0]      word,
    output logic [LEN_W-1:0] span_len,
    output logic [ROW_W-1:0] row
);
    logic [31:0] scaled;

    // Drop the fractional bits, clamp the length, extract the row.
    always_comb begin
        scaled = word >> FRAC_BITS;
        row    = scaled[ROW_W-1:0];
        if (scaled > 32'(FB_COLS))
            span_len = LEN_W'(FB_COLS);
        else
            span_len = scaled[LEN_W-1:0];
    end
endmodule

// File: rtl/spancopy_dirty_box.sv
`timescale 1ns/1ps
// Keeps the lowest and highest row touched. A clear in the same cycle as an
// update leaves only the new pair of rows. Assumes at most one update per cycle.
module spancopy_dirty_box #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [ROW_W-1:0] row_a,
    input  logic [ROW_W-1:0] row_b,
    output logic             valid,
    output logic [ROW_W-1:0] lo,
    output logic [ROW_W-1:0] hi
);
    logic [ROW_W-1:0] pair_lo, pair_hi;

    // Order the incoming pair of rows.
    always_comb begin
        pair_lo = (row_a < row_b) ? row_a : row_b;
        pair_hi = (row_a < row_b) ? row_b : row_a;
    end

    // Merge, restart or clear the stored range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            lo    <= '0;
            hi    <= '0;
        end else if (upd) begin
            valid <= 1'b1;
            if (clr || !valid) begin
                lo <= pair_lo;
                hi <= pair_hi;
            end else begin
                lo <= (pair_lo < lo) ? pair_lo : lo;
                hi <= (pair_hi > hi) ? pair_hi : hi;
            end
        end else if (clr) begin
            valid <= 1'b0;
            lo    <= '0;
            hi    <= '0;
        end
    end
endmodule

// File: rtl/spancopy_pixel_mover.sv
`timescale 1ns/1ps
// Streams one span: a read per cycle from ascending source addresses, then a
// write one cycle later to the matching destination address. Assumes the
// framebuffer returns read data one cycle after the read enable, and that
// load only arrives while idle.
module spancopy_pixel_mover #(
    parameter int FB_AW = 21,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FB_AW-1:0] src_base,
    input  logic [FB_AW-1:0] dst_base,
    input  logic [LEN_W-1:0] len,
    output logic             rd_en,
    output logic [FB_AW-1:0] rd_addr,
    output logic             wr_en,
    output logic [FB_AW-1:0] wr_addr,
    output logic             idle
);
    logic [LEN_W-1:0] remain;
    logic [FB_AW-1:0] rd_ptr, wr_ptr, wr_addr_q;
    logic             wr_q;

    assign rd_en   = (remain != '0);
    assign rd_addr = rd_ptr;
    assign wr_en   = wr_q;
    assign wr_addr = wr_addr_q;
    assign idle    = (remain == '0) && !wr_q;

    // Advance the pointers and delay each write by one cycle behind its read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            wr_addr_q <= '0;
            wr_q      <= 1'b0;
        end else begin
            wr_q <= rd_en;
            if (rd_en)
                wr_addr_q <= wr_ptr;
            if (load) begin
                remain <= len;
                rd_ptr <= src_base;
                wr_ptr <= dst_base;
            end else if (rd_en) begin
                remain <= remain - LEN_W'(1);
                rd_ptr <= rd_ptr + FB_AW'(1);
                wr_ptr <= wr_ptr + FB_AW'(1);
            end
        end
    end
endmodule

// File: rtl/span_copy_engine.sv
`timescale 1ns/1ps
// Executes a span-copy command packet. It fetches the header, then each
// descriptor in turn, and moves each span row to row. The read data of both
// memories must arrive one cycle after the read enable. Each span completes
// before the next descriptor is fetched.
module span_copy_engine
    import spancopy_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int FB_COLS = 1280,
    parameter int FB_ROWS = 1024,
    parameter int CMD_AW  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [CMD_AW-1:0]             pkt_base,
    output logic                          cmd_rd_en,
    output logic [CMD_AW-1:0]             cmd_rd_addr,
    input  logic [31:0]                   cmd_rd_data,
    output logic                          fb_rd_en,
    output logic [$clog2(FB_COLS*FB_ROWS)-1:0] fb_rd_addr,
    input  logic [PIX_W-1:0]              fb_rd_data,
    output logic                          fb_wr_en,
    output logic [$clog2(FB_COLS*FB_ROWS)-1:0] fb_wr_addr,
    output logic [PIX_W-1:0]              fb_wr_data,
    output logic                          busy,
    output logic                          done,
    input  logic                          dirty_clr,
    output logic                          dirty_valid,
    output logic [$clog2(FB_ROWS)-1:0]    dirty_row_lo,
    output logic [$clog2(FB_ROWS)-1:0]    dirty_row_hi
);
    localparam int ROW_W = $clog2(FB_ROWS);
    localparam int LEN_W = $clog2(FB_COLS + 1);
    localparam int FB_AW = $clog2(FB_COLS * FB_ROWS);

    seq_state_e        state, nxt;
    logic [CMD_AW-1:0] base_q, ptr;
    logic [CNT_W-1:0]  spans_left;
    logic [LEN_W-1:0]  len_q, f_len;
    logic [ROW_W-1:0]  src_row_q, f_row;
    logic [FB_AW-1:0]  src_base, dst_base;
    logic              load, upd, adv, mv_idle;

    spancopy_field_decode #(.FB_COLS(FB_COLS), .ROW_W(ROW_W), .LEN_W(LEN_W)) u_dec (
        .word(cmd_rd_data), .span_len(f_len), .row(f_row)
    );

    assign src_base = FB_AW'(src_row_q) * FB_AW'(FB_COLS);
    assign dst_base = FB_AW'(f_row) * FB_AW'(FB_COLS);

    spancopy_pixel_mover #(.FB_AW(FB_AW), .LEN_W(LEN_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .load(load),
        .src_base(src_base), .dst_base(dst_base), .len(len_q),
        .rd_en(fb_rd_en), .rd_addr(fb_rd_addr),
        .wr_en(fb_wr_en), .wr_addr(fb_wr_addr), .idle(mv_idle)
    );

    spancopy_dirty_box #(.ROW_W(ROW_W)) u_dirty (
        .clk(clk), .rst_n(rst_n), .clr(dirty_clr), .upd(upd),
        .row_a(src_row_q), .row_b(f_row),
        .valid(dirty_valid), .lo(dirty_row_lo), .hi(dirty_row_hi)
    );

    assign fb_wr_data = fb_rd_data;
    assign busy       = (state != ST_IDLE) && (state != ST_FIN);
    assign done       = (state == ST_FIN);

    // Sequencer: choose the next state and the command fetch for this cycle.
    always_comb begin
        nxt         = state;
        cmd_rd_en   = 1'b0;
        cmd_rd_addr = ptr;
        load        = 1'b0;
        upd         = 1'b0;
        adv         = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                cmd_rd_en   = 1'b1;
                cmd_rd_addr = pkt_base;
                nxt         = ST_HDR;
            end
            ST_HDR: if (cmd_rd_data == OPC_SPAN_COPY) begin
                cmd_rd_en   = 1'b1;
                cmd_rd_addr = base_q + CMD_AW'(1);
                nxt         = ST_CNT;
            end else begin
                nxt = ST_FIN;
            end
            ST_CNT: if (cmd_rd_data[CNT_LSB +: CNT_W] == '0) begin
                nxt = ST_FIN;
            end else begin
                cmd_rd_en   = 1'b1;
                cmd_rd_addr = base_q + CMD_AW'(HDR_WORDS);
                nxt         = ST_LEN;
            end
            ST_LEN: begin
                cmd_rd_en = 1'b1;
                nxt       = ST_SRC;
            end
            ST_SRC: begin
                cmd_rd_en = 1'b1;
                nxt       = ST_DST;
            end
            ST_DST: begin
                upd = 1'b1;
                if (len_q != '0) begin
                    load = 1'b1;
                    nxt  = ST_MOVE;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_MOVE: adv = mv_idle;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (adv) begin
            if (spans_left == CNT_W'(1)) begin
                nxt = ST_FIN;
            end else begin
                cmd_rd_en = 1'b1;
                nxt       = ST_LEN;
            end
        end
    end

    // Sequencer registers: state, fetch pointer, span counter, latched fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            base_q     <= '0;
            ptr        <= '0;
            spans_left <= '0;
            len_q      <= '0;
            src_row_q  <= '0;
        end else begin
            state <= nxt;
            if (cmd_rd_en)
                ptr <= cmd_rd_addr + CMD_AW'(1);
            if (state == ST_IDLE && start)
                base_q <= pkt_base;
            if (state == ST_CNT)
                spans_left <= cmd_rd_data[CNT_LSB +: CNT_W];
            else if (adv)
                spans_left <= spans_left - CNT_W'(1);
            if (state == ST_LEN)
                len_q <= f_len;
            if (state == ST_SRC)
                src_row_q <= f_row;
        end
    end
endmodule

// File: rtl/span_copy_engine_chk.sv
`timescale 1ns/1ps
// Property checker for the span copy engine, attached by bind below.
module span_copy_engine_chk #(
    parameter int FB_AW = 21,
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             cmd_rd_en,
    input logic             fb_rd_en,
    input logic [FB_AW-1:0] fb_rd_addr,
    input logic             fb_wr_en,
    input logic [FB_AW-1:0] fb_wr_addr,
    input logic             dirty_clr,
    input logic             dirty_valid,
    input logic [ROW_W-1:0] dirty_row_lo,
    input logic [ROW_W-1:0] dirty_row_hi
);
    AST_RD_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd_en && $past(fb_rd_en)) |-> (fb_rd_addr == FB_AW'($past(fb_rd_addr) + 1'b1))) else $error("AST_RD_ASCENDING"); // R5
    AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_wr_en && $past(fb_wr_en)) |-> (fb_wr_addr == FB_AW'($past(fb_wr_addr) + 1'b1))) else $error("AST_WR_ASCENDING"); // R5
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr_en |-> $past(fb_rd_en)) else $error("AST_WR_AFTER_RD"); // R5
    AST_FB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rd_en || fb_wr_en) |-> busy) else $error("AST_FB_WHILE_BUSY"); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))) else $error("AST_DONE_ENDS_BUSY"); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("AST_DONE_SINGLE"); // R6
    AST_FETCH_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd_en && !busy) |-> start) else $error("AST_FETCH_NEEDS_START"); // R7
    AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_valid |-> (dirty_row_lo <= dirty_row_hi)) else $error("AST_RANGE_ORDERED"); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_clr && !busy) |=> !dirty_valid) else $error("AST_CLEAR_EMPTIES"); // R9
endmodule

bind span_copy_engine span_copy_engine_chk #(.FB_AW(FB_AW), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cmd_rd_en(cmd_rd_en), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
    .fb_wr_en(fb_wr_en), .fb_wr_addr(fb_wr_addr), .dirty_clr(dirty_clr),
    .dirty_valid(dirty_valid), .dirty_row_lo(dirty_row_lo), .dirty_row_hi(dirty_row_hi)
);

// File: tb/span_copy_engine_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural packet and framebuffer model, with per-cycle comparison.
module span_copy_engine_tb;
    localparam int PIX_W = 24;
    localparam int COLS  = 1280;
    localparam int ROWS  = 1024;
    localparam int CAW   = 10;
    localparam int FAW   = $clog2(COLS * ROWS);
    localparam int RW    = $clog2(ROWS);

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             start = 1'b0, dirty_clr = 1'b0;
    logic [CAW-1:0]   pkt_base = '0;
    logic             cmd_rd_en;
    logic [CAW-1:0]   cmd_rd_addr;
    logic [31:0]      cmd_rd_data = '0;
    logic             fb_rd_en, fb_wr_en, busy, done, dirty_valid;
    logic [FAW-1:0]   fb_rd_addr, fb_wr_addr;
    logic [PIX_W-1:0] fb_rd_data = '0, fb_wr_data;
    logic [RW-1:0]    dirty_row_lo, dirty_row_hi;

    span_copy_engine #(.PIX_W(PIX_W), .FB_COLS(COLS), .FB_ROWS(ROWS), .CMD_AW(CAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pkt_base(pkt_base),
        .cmd_rd_en(cmd_rd_en), .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
        .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .fb_wr_en(fb_wr_en), .fb_wr_addr(fb_wr_addr), .fb_wr_data(fb_wr_data),
        .busy(busy), .done(done), .dirty_clr(dirty_clr), .dirty_valid(dirty_valid),
        .dirty_row_lo(dirty_row_lo), .dirty_row_hi(dirty_row_hi)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory models on the design side.
    logic [31:0]      cmem [0:(1<<CAW)-1];
    logic [PIX_W-1:0] fbm [int];
    logic [PIX_W-1:0] rfb [int];

    function automatic logic [PIX_W-1:0] pat(input int a);
        logic [31:0] h;
        h = (a * 32'h9E37_79B1) ^ 32'h00C3_A55A;
        return h[PIX_W-1:0];
    endfunction

    always @(posedge clk) begin
        if (cmd_rd_en) cmd_rd_data <= cmem[cmd_rd_addr];
        if (fb_wr_en) fbm[int'(fb_wr_addr)] = fb_wr_data;
        if (fb_rd_en)
            fb_rd_data <= fbm.exists(int'(fb_rd_addr)) ? fbm[int'(fb_rd_addr)] : pat(int'(fb_rd_addr));
    end

    // Reference model state.
    int               exp_wa[$];
    logic [PIX_W-1:0] exp_wd[$];
    int               q_len[$], q_src[$], q_dst[$];
    bit               e_valid = 0;
    int               e_lo = 0, e_hi = 0;
    int               m_arm = 0, m_left = 0;
    bit               m_done = 0, mon_on = 0;

    function automatic logic [PIX_W-1:0] ref_rd(input int a);
        return rfb.exists(a) ? rfb[a] : pat(a);
    endfunction

    task automatic merge(input int a, input int b);
        int lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (!e_valid) begin e_lo = lo; e_hi = hi; e_valid = 1; end
        else begin
            if (lo < e_lo) e_lo = lo;
            if (hi > e_hi) e_hi = hi;
        end
    endtask

    // Write a packet at base, predict its writes, dirty range and busy length.
    task automatic build(input int base, input logic [31:0] w0, input logic [31:0] w1,
                         output int blen);
        int n;
        logic [31:0] sl, ss, sd;
        cmem[base] = w0;
        cmem[base+1] = w1;
        for (int i = 2; i < 5; i++) cmem[base+i] = 32'hDEAD_0000 + i;
        for (int i = 0; i < q_len.size(); i++) begin
            cmem[base+5+3*i]   = q_len[i];
            cmem[base+5+3*i+1] = q_src[i];
            cmem[base+5+3*i+2] = q_dst[i];
        end
        if (w0 != 32'h0000_0405) blen = 1;
        else begin
            n = int'(w1[31:24]);
            blen = 2;
            for (int i = 0; i < n; i++) begin
                int len, sr, dr;
                sl = q_len[i]; ss = q_src[i]; sd = q_dst[i];
                len = ((sl >> 3) > COLS) ? COLS : int'(sl >> 3);
                sr = int'((ss >> 3) & (ROWS - 1));
                dr = int'((sd >> 3) & (ROWS - 1));
                blen += 3;
                if (len > 0) blen += len + 2;
                merge(sr, dr);
                for (int c = 0; c < len; c++) begin
                    logic [PIX_W-1:0] v;
                    v = ref_rd(sr * COLS + c);
                    rfb[dr * COLS + c] = v;
                    exp_wa.push_back(dr * COLS + c);
                    exp_wd.push_back(v);
                end
            end
        end
        q_len.delete(); q_src.delete(); q_dst.delete();
    endtask

    task automatic span(input int l, input int s, input int d);
        q_len.push_back(l); q_src.push_back(s); q_dst.push_back(d);
    endtask

    // Per-cycle comparison of busy, done and every framebuffer write.
    always @(negedge clk) begin
        if (mon_on) begin
            if (m_arm > 0) begin m_left = m_arm; m_arm = 0; end
            chk(busy === (m_left > 0), "R6", "busy", longint'(busy), longint'(m_left > 0));
            chk(done === m_done, "R6", "done", longint'(done), longint'(m_done));
            if (fb_wr_en) begin
                if (exp_wa.size() == 0) chk(0, "R5", "unexpected write addr", longint'(fb_wr_addr), -1);
                else begin
                    int a;
                    logic [PIX_W-1:0] d;
                    a = exp_wa.pop_front();
                    d = exp_wd.pop_front();
                    chk(int'(fb_wr_addr) == a, "R5", "write addr", longint'(fb_wr_addr), longint'(a));
                    chk(fb_wr_data === d, "R5", "write data", longint'(fb_wr_data), longint'(d));
                end
            end
            if (m_left > 0) begin m_left--; m_done = (m_left == 0); end
            else m_done = 0;
        end
    end

    // Launch a command; optionally poke start (to alt) and/or clear at loop step.
    task automatic run(input int base, input int blen, input int poke_start,
                       input int alt, input int poke_clr, input string req);
        @(negedge clk); #1;
        start = 1'b1; pkt_base = CAW'(base); m_arm = blen;
        @(negedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < blen + 3; k++) begin
            @(negedge clk); #1;
            start     = (k == poke_start);
            if (k == poke_start) pkt_base = CAW'(alt);
            dirty_clr = (k == poke_clr);
        end
        start = 1'b0; dirty_clr = 1'b0;
        chk(exp_wa.size() == 0, req, "writes still expected", exp_wa.size(), 0);
    endtask

    task automatic chk_dirty(input string req);
        chk(dirty_valid === e_valid, req, "dirty_valid", longint'(dirty_valid), longint'(e_valid));
        if (e_valid) begin
            chk(int'(dirty_row_lo) == e_lo, req, "dirty_row_lo", longint'(dirty_row_lo), e_lo);
            chk(int'(dirty_row_hi) == e_hi, req, "dirty_row_hi", longint'(dirty_row_hi), e_hi);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_bad++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 60000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy == 0, "R10", "busy", busy, 0);
        chk(done == 0, "R10", "done", done, 0);
        chk(dirty_valid == 0, "R10", "dirty_valid", dirty_valid, 0);
        chk(fb_rd_en == 0 && fb_wr_en == 0, "R10", "fb enables", fb_rd_en | fb_wr_en, 0);
        chk(cmd_rd_en == 0, "R10", "cmd_rd_en", cmd_rd_en, 0);
        mon_on = 1;

        // R2 R3 R5: two spans, junk in low bits of the count word and fractions
        span(5 << 3, 3 << 3, 7 << 3);
        span((3 << 3) | 7, (10 << 3) | 5, 2 << 3);
        build(0, 32'h405, 32'h0200_1234, b);
        run(0, b, -1, 0, -1, "R5");
        chk_dirty("R3");

        // R1: wrong command words do nothing
        span(4 << 3, 1 << 3, 900 << 3);
        build(100, 32'h404, 32'h0100_0000, b);
        chk(b == 1, "R1", "predicted busy", b, 1);
        run(100, b, -1, 0, -1, "R1");
        chk_dirty("R1");
        span(4 << 3, 1 << 3, 900 << 3);
        build(110, 32'h1405, 32'h0100_0000, b);
        run(110, b, -1, 0, -1, "R1");
        chk_dirty("R1");

        // R2: zero span count
        build(130, 32'h405, 32'h00FF_FFFF, b);
        run(130, b, -1, 0, -1, "R2");
        chk_dirty("R2");

        // R4 R3 R8: clamp, zero length, row wrap, exact full row
        span((2000 << 3) | 1, 1029 << 3, 1000 << 3);
        span(5, 1 << 3, 1023 << 3);
        span(1280 << 3, 1000 << 3, 6 << 3);
        build(200, 32'h405, 32'h0300_0000, b);
        run(200, b, -1, 0, -1, "R4");
        chk_dirty("R8");

        // R9: clear while idle
        @(negedge clk); #1 dirty_clr = 1'b1;
        @(negedge clk); #1 dirty_clr = 1'b0;
        e_valid = 0;
        chk(dirty_valid == 0, "R9", "dirty_valid after clear", dirty_valid, 0);
        chk(dirty_row_lo == 0 && dirty_row_hi == 0, "R9", "bounds after clear",
            dirty_row_lo | dirty_row_hi, 0);

        // R8: range accumulates across commands
        span(2 << 3, 40 << 3, 50 << 3);
        build(300, 32'h405, 32'h0100_0000, b);
        run(300, b, -1, 0, -1, "R8");
        span(1 << 3, 60 << 3, 45 << 3);
        build(340, 32'h405, 32'h0100_0000, b);
        run(340, b, -1, 0, -1, "R8");
        chk_dirty("R8");

        // R9 R7: clear coincides with the span update; start while busy ignored
        e_valid = 0;
        span(4 << 3, 12 << 3, 11 << 3);
        build(400, 32'h405, 32'h0100_0000, b);
        run(400, b, 3, 300, 3, "R7");
        chk_dirty("R9");

        // R5: copy of a row onto itself
        span(3 << 3, 20 << 3, 20 << 3);
        build(440, 32'h405, 32'h0100_0000, b);
        run(440, b, -1, 0, -1, "R5");
        chk_dirty("R8");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule